// File: doc/BRIEF.md
# Streaming Port Access Controller

This block carries out the get and put instructions of a processor against a set of one-way streaming ports. Each port has a receive side (word, tag bit, a data-present flag and a pop strobe) and a transmit side (word, tag bit, a back-pressure flag and a push strobe). The controller takes the instruction word and the source operand from the execute stage. It works out which port is addressed and in which direction, whether the access may wait, and whether the word is plain data or a control word. It then raises the pop or push strobe of that one port.

A blocking access that cannot finish holds the pipeline through a stall output. A non-blocking access never waits. It reports whether it went through by writing the carry flag. A completed read hands the word to the register write-back one cycle later. If the tag bit of that word does not match the kind of read, a stream-error status pulse is raised at the same time.

Top module: `stream_port_ctrl`

## Requirements
- R1: An instruction is a port access only when `instr_valid` is high, `instr[31:26]` equals 6'b011011 and `instr[2:0]` names a present port (below NPORT). Any other word raises no strobe and no stall, and writes neither the register nor the carry flag.
- R2: A blocking read (`instr[15]`=0, `instr[14]`=0) keeps `stall` high, with no strobe, while the addressed port's `rx_exists` is low. In the cycle it is high, `stall` is low and that port's `rx_pop` pulses.
- R3: A blocking write (`instr[15]`=1, `instr[14]`=0) keeps `stall` high, with no strobe, while the addressed port's `tx_full` is high. In the cycle it is low, `stall` is low and that port's `tx_push` pulses.
- R4: A non-blocking access (`instr[14]`=1) never raises `stall`. If it cannot complete, it raises no strobe and leaves `rd_we` low.
- R5: One cycle after a non-blocking access, `carry_we` is high and `carry_val` is the inverse of `rx_exists` for a read, or equal to `tx_full` for a write. Blocking accesses leave `carry_we` low.
- R6: During a push, `tx_data` equals `op_a` and `tx_ctrl` equals `instr[13]`. So a data write sends tag 0 and a control write sends tag 1.
- R7: One cycle after a pop, `rd_we` is high and `rd_data` holds the popped port's `rx_data` word. `rd_we` is high at no other time.
- R8: One cycle after a pop, `serr_set` is high exactly when the popped tag bit differs from `instr[13]`: a data read that sees tag 1, or a control read that sees tag 0. It is low at all other times.
- R9: At most one strobe is high in a cycle across all `rx_pop` and `tx_push` bits, and it belongs to the addressed port. Each strobe lasts one cycle per completed access.
- R10: After reset, `rd_we`, `carry_we`, `serr_set`, `carry_val` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Execute stage holds a valid instruction |
| instr | input | 32 | Instruction word, held by the pipeline while `stall` is high |
| op_a | input | W | Source operand for writes |
| stall | output | 1 | Blocking access cannot complete this cycle |
| rd_we | output | 1 | Register write-back enable, one cycle after a pop |
| rd_data | output | W | Word popped from the port |
| carry_we | output | 1 | Carry flag write enable from a non-blocking access |
| carry_val | output | 1 | New carry value (1 = access failed) |
| serr_set | output | 1 | Stream-error status pulse on tag mismatch |
| rx_data | input | NPORT*W | Receive words, port p at bits p*W +: W |
| rx_ctrl | input | NPORT | Receive tag bits |
| rx_exists | input | NPORT | Receive side holds a word |
| rx_pop | output | NPORT | Pop strobe for each port |
| tx_data | output | W | Transmit word shared by all ports |
| tx_ctrl | output | 1 | Transmit tag bit shared by all ports |
| tx_full | input | NPORT | Transmit side cannot accept a word |
| tx_push | output | NPORT | Push strobe for each port |

## Verification
The stall, the strobes and the transmit word and tag come from the current instruction and port flags with no register between them. The bench therefore checks them in the same cycle, a moment before the rising edge. Register data, carry and the stream-error pulse pass through one register and are due one edge later. The bench holds the expected values from the pre-edge check and compares them just after that edge. Long blocking waits are built by holding the instruction over several cycles and releasing the flag, so the strobe is expected only in the release cycle.

// File: rtl/stream_port_pkg.sv
package stream_port_pkg;

  localparam logic [5:0] ACC_OPCODE = 6'b011011;
  localparam int         PORT_BITS  = 3;

  // Decoded view of one streaming access
  typedef struct packed {
    logic                 hit;      // valid port access to a present port
    logic                 is_put;   // 1 = transmit, 0 = receive
    logic                 nonblk;   // 1 = never waits
    logic                 is_ctrl;  // 1 = control word
    logic [PORT_BITS-1:0] port;
  } acc_t;

  function automatic acc_t f_decode(input logic [31:0] ins, input logic vld, input int nport);
    acc_t d;
    d.is_put  = ins[15];
    d.nonblk  = ins[14];
    d.is_ctrl = ins[13];
    d.port    = ins[PORT_BITS-1:0];
    d.hit     = vld && (ins[31:26] == ACC_OPCODE) && (int'(ins[PORT_BITS-1:0]) < nport);
    return d;
  endfunction

  // Port side can serve the access this cycle
  function automatic logic f_ready(input logic is_put, input logic exists, input logic full);
    return is_put ? !full : exists;
  endfunction

  // Carry reports a failed non-blocking access
  function automatic logic f_carry(input logic is_put, input logic exists, input logic full);
    return is_put ? full : !exists;
  endfunction

  // Tag bit disagrees with the kind of read
  function automatic logic f_tag_err(input logic is_ctrl, input logic tag);
    return tag ^ is_ctrl;
  endfunction

endpackage

// File: rtl/spc_decoder.sv
module spc_decoder
  import stream_port_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic [31:0] instr,
  input  logic        instr_valid,
  output acc_t        dec
);
  always_comb dec = f_decode(instr, instr_valid, NPORT);
endmodule

// File: rtl/spc_port_select.sv
module spc_port_select
  import stream_port_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int W     = 32
) (
  input  logic [PORT_BITS-1:0] port,
  input  logic [NPORT*W-1:0]   rx_data,
  input  logic [NPORT-1:0]     rx_ctrl,
  input  logic [NPORT-1:0]     rx_exists,
  input  logic [NPORT-1:0]     tx_full,
  input  logic                 rd_go,
  input  logic                 wr_go,
  output logic [W-1:0]         sel_data,
  output logic                 sel_ctrl,
  output logic                 sel_exists,
  output logic                 sel_full,
  output logic [NPORT-1:0]     rx_pop,
  output logic [NPORT-1:0]     tx_push
);
  always_comb begin
    sel_data   = '0;
    sel_ctrl   = 1'b0;
    sel_exists = 1'b0;
    sel_full   = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (int'(port) == p) begin
        sel_data   = rx_data[p*W +: W];
        sel_ctrl   = rx_ctrl[p];
        sel_exists = rx_exists[p];
        sel_full   = tx_full[p];
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_strobe
    logic addr_match;
    assign addr_match = (int'(port) == g);
    assign rx_pop[g]  = rd_go && addr_match;
    assign tx_push[g] = wr_go && addr_match;
  end
endmodule

// File: rtl/spc_result_reg.sv
module spc_result_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_we_nx,
  input  logic [W-1:0] rd_data_nx,
  input  logic         carry_we_nx,
  input  logic         carry_val_nx,
  input  logic         serr_nx,
  output logic         rd_we,
  output logic [W-1:0] rd_data,
  output logic         carry_we,
  output logic         carry_val,
  output logic         serr_set
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_we     <= 1'b0;
      rd_data   <= '0;
      carry_we  <= 1'b0;
      carry_val <= 1'b0;
      serr_set  <= 1'b0;
    end else begin
      rd_we    <= rd_we_nx;
      carry_we <= carry_we_nx;
      serr_set <= serr_nx;
      if (rd_we_nx)    rd_data   <= rd_data_nx;
      if (carry_we_nx) carry_val <= carry_val_nx;
    end
  end
endmodule

// File: rtl/stream_port_ctrl.sv
module stream_port_ctrl
  import stream_port_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [31:0]        instr,
  input  logic [W-1:0]       op_a,
  output logic               stall,
  output logic               rd_we,
  output logic [W-1:0]       rd_data,
  output logic               carry_we,
  output logic               carry_val,
  output logic               serr_set,
  input  logic [NPORT*W-1:0] rx_data,
  input  logic [NPORT-1:0]   rx_ctrl,
  input  logic [NPORT-1:0]   rx_exists,
  output logic [NPORT-1:0]   rx_pop,
  output logic [W-1:0]       tx_data,
  output logic               tx_ctrl,
  input  logic [NPORT-1:0]   tx_full,
  output logic [NPORT-1:0]   tx_push
);
  acc_t         dec;
  logic [W-1:0] sel_data;
  logic         sel_ctrl, sel_exists, sel_full;
  logic         port_ready;
  logic         rd_go, wr_go;
  logic         nb_access;

  spc_decoder #(.NPORT(NPORT)) u_dec (
    .instr       (instr),
    .instr_valid (instr_valid),
    .dec         (dec)
  );

  assign port_ready = f_ready(dec.is_put, sel_exists, sel_full);
  assign rd_go      = dec.hit && !dec.is_put && port_ready;
  assign wr_go      = dec.hit &&  dec.is_put && port_ready;
  assign nb_access  = dec.hit && dec.nonblk;
  assign stall      = dec.hit && !dec.nonblk && !port_ready;

  spc_port_select #(.NPORT(NPORT), .W(W)) u_sel (
    .port       (dec.port),
    .rx_data    (rx_data),
    .rx_ctrl    (rx_ctrl),
    .rx_exists  (rx_exists),
    .tx_full    (tx_full),
    .rd_go      (rd_go),
    .wr_go      (wr_go),
    .sel_data   (sel_data),
    .sel_ctrl   (sel_ctrl),
    .sel_exists (sel_exists),
    .sel_full   (sel_full),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push)
  );

  assign tx_data = op_a;
  assign tx_ctrl = dec.is_ctrl;

  spc_result_reg #(.W(W)) u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_we_nx     (rd_go),
    .rd_data_nx   (sel_data),
    .carry_we_nx  (nb_access),
    .carry_val_nx (f_carry(dec.is_put, sel_exists, sel_full)),
    .serr_nx      (rd_go && f_tag_err(dec.is_ctrl, sel_ctrl)),
    .rd_we        (rd_we),
    .rd_data      (rd_data),
    .carry_we     (carry_we),
    .carry_val    (carry_val),
    .serr_set     (serr_set)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int NPORT = 8,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic [NPORT-1:0] rx_pop,
  input logic [NPORT-1:0] tx_push,
  input logic             rd_we,
  input logic [W-1:0]     rd_data,
  input logic             carry_we,
  input logic             serr_set,
  input logic [W-1:0]     sel_data,
  input logic             nb_access
);
  // R9
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rx_pop));
  // R9
  push_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_push));
  // R9
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !((|rx_pop) && (|tx_push)));
  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) stall |-> (rx_pop == '0 && tx_push == '0));
  // R4
  nb_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) nb_access |-> !stall);
  // R7
  pop_wb_chk: assert property (@(posedge clk) disable iff (!rst_n) (|rx_pop) |=> rd_we);
  // R7
  pop_word_chk: assert property (@(posedge clk) disable iff (!rst_n) (|rx_pop) |=> rd_data == $past(sel_data));
  // R7
  wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_we |-> $past(|rx_pop));
  // R8
  serr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) serr_set |-> $past(|rx_pop));
  // R5
  carry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) carry_we |-> $past(nb_access));
endmodule

bind stream_port_ctrl spc_checker #(.NPORT(NPORT), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .rx_pop    (rx_pop),
  .tx_push   (tx_push),
  .rd_we     (rd_we),
  .rd_data   (rd_data),
  .carry_we  (carry_we),
  .serr_set  (serr_set),
  .sel_data  (sel_data),
  .nb_access (nb_access)
);

// File: tb/stream_port_ctrl_tb.sv
module stream_port_ctrl_tb;
  localparam int NP = 8;
  localparam int W  = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [W-1:0] op_a = '0;
  logic stall, rd_we, carry_we, carry_val, serr_set, tx_ctrl;
  logic [W-1:0] rd_data, tx_data;
  logic [NP*W-1:0] rx_data = '0;
  logic [NP-1:0] rx_ctrl = '0, rx_exists = '0, tx_full = '0, rx_pop, tx_push;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_port_ctrl #(.NPORT(NP), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .op_a(op_a),
    .stall(stall), .rd_we(rd_we), .rd_data(rd_data), .carry_we(carry_we),
    .carry_val(carry_val), .serr_set(serr_set), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .rx_exists(rx_exists), .rx_pop(rx_pop), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
    .tx_full(tx_full), .tx_push(tx_push)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Field helpers use MSB-first numbering: bit n of the word is instr[31-n]
  function automatic logic fld(input logic [31:0] w, input int n);
    return w[31-n];
  endfunction

  function automatic logic [31:0] mk(input bit put, input bit nb, input bit ctl, input int p);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = 6'b011011;
    w[15] = put; w[14] = nb; w[13] = ctl;
    w[2:0] = p[2:0];
    return w;
  endfunction

  // One instruction cycle: drive after negedge, check combinational outputs
  // before posedge, check registered results after it.
  task automatic step(input logic [31:0] ins, input logic v, input logic [NP-1:0] ex,
                      input logic [NP-1:0] fu, input logic [NP-1:0] ct);
    bit acc, put, nb, ctl, can, e_stall, e_rdwe, e_cwe, e_cval, e_serr;
    int p;
    logic [NP-1:0] e_pop, e_push;
    logic [W-1:0] e_word;
    @(negedge clk);
    instr = ins; instr_valid = v; op_a = $urandom;
    rx_exists = ex; tx_full = fu; rx_ctrl = ct;
    for (int k = 0; k < NP; k++) rx_data[k*W +: W] = $urandom;
    #1;
    acc = v && ({fld(ins,0),fld(ins,1),fld(ins,2),fld(ins,3),fld(ins,4),fld(ins,5)} == 6'b011011);
    p   = {fld(ins,29), fld(ins,30), fld(ins,31)};
    put = fld(ins,16); nb = fld(ins,17); ctl = fld(ins,18);
    can = put ? (fu[p] == 1'b0) : (ex[p] == 1'b1);
    e_stall = acc && !nb && !can;
    e_pop = '0; e_push = '0;
    if (acc && can && !put) e_pop[p] = 1'b1;
    if (acc && can && put)  e_push[p] = 1'b1;
    e_rdwe = acc && can && !put;
    e_word = rx_data[p*W +: W];
    e_cwe  = acc && nb;
    e_cval = put ? fu[p] : !ex[p];
    e_serr = e_rdwe && (ct[p] != ctl);
    check(nb ? "R4" : (put ? "R3" : "R2"), "stall", W'(stall), W'(e_stall));
    check("R9", "rx_pop", W'(rx_pop), W'(e_pop));
    check("R9", "tx_push", W'(tx_push), W'(e_push));
    if (|e_push) begin
      check("R6", "tx_data", tx_data, op_a);
      check("R6", "tx_ctrl", W'(tx_ctrl), W'(ctl));
    end
    @(posedge clk); #1;
    check("R7", "rd_we", W'(rd_we), W'(e_rdwe));
    if (e_rdwe) check("R7", "rd_data", rd_data, e_word);
    check("R5", "carry_we", W'(carry_we), W'(e_cwe));
    if (e_cwe) check("R5", "carry_val", W'(carry_val), W'(e_cval));
    check("R8", "serr_set", W'(serr_set), W'(e_serr));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10", "rd_we", W'(rd_we), '0);
    check("R10", "carry_we", W'(carry_we), '0);
    check("R10", "serr_set", W'(serr_set), '0);
    check("R10", "carry_val", W'(carry_val), '0);
    check("R10", "rd_data", rd_data, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2: blocking read on port 5 waits three cycles, then pops
    begin
      logic [31:0] w = mk(0, 0, 0, 5);
      repeat (3) step(w, 1, 8'hDF, 8'h00, 8'h00);
      step(w, 1, 8'h20, 8'h00, 8'h00);
    end
    // R3: blocking control write on port 2 held off by full
    begin
      logic [31:0] w = mk(1, 0, 1, 2);
      repeat (3) step(w, 1, 8'hFF, 8'h04, 8'h00);
      step(w, 1, 8'hFF, 8'hFB, 8'h00);
    end
    // R6: data write sends tag 0
    step(mk(1, 0, 0, 7), 1, 8'h00, 8'h00, 8'hFF);
    // R4 R5: failed non-blocking read and write
    step(mk(0, 1, 0, 3), 1, 8'hF7, 8'h00, 8'h00);
    step(mk(1, 1, 1, 0), 1, 8'h00, 8'h01, 8'h00);
    // R5: successful non-blocking read and write
    step(mk(0, 1, 1, 1), 1, 8'h02, 8'h00, 8'h02);
    step(mk(1, 1, 0, 6), 1, 8'h00, 8'hBF, 8'h00);
    // R8: data read sees tag 1, control read sees tag 0
    step(mk(0, 0, 0, 4), 1, 8'hFF, 8'h00, 8'h10);
    step(mk(0, 0, 1, 4), 1, 8'hFF, 8'h00, 8'h00);
    // R1: wrong opcode and invalid cycle
    begin
      logic [31:0] w = mk(0, 0, 0, 1);
      w[31:26] = 6'b011010;
      step(w, 1, 8'h00, 8'hFF, 8'h00);
      step(mk(0, 0, 0, 1), 0, 8'h00, 8'hFF, 8'h00);
    end
    // Random mix, one blocking access in four released by coin-flip flags
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w = mk($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,7));
      if ($urandom_range(0,9) == 0) w[31:26] = 6'($urandom);
      step(w, $urandom_range(0,7) != 0, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule